// File: doc/BRIEF.md
# PCI Target Transaction Decoder

This block controls the address and data phases of a PCI target. It watches the FRAME#, IRDY#, C/BE# and AD lines and takes the command and address from the clock in which FRAME# first goes low. A dual address cycle takes one extra clock and produces a full 64-bit address. The block claims a transaction only when the command is one it serves and the address lies inside a base/limit window supplied on input ports.

DEVSEL# uses medium decode timing. The target is always ready, so TRDY# is asserted together with DEVSEL#. A burst advances the address by one bus word on every completed data phase. A memory burst whose two lowest address bits are not zero gets exactly one transfer, followed by a disconnect. When the transaction ends, the block drives its three control lines high for one clock and then releases them.

The outputs report the following:
- whether the transaction is claimed
- the command
- the address of the current data phase
- a strobe that marks each completed data transfer

Top module: `pci_tgt_decode`

## Requirements
- R1: While reset is applied and just after it, devsel_n, trdy_n and stop_n are 1, and ctl_oe, claimed and xfer_stb are 0.
- R2: The target serves the command codes 0010 I/O read, 0011 I/O write, 0110 memory read, 0111 memory write, 1100 memory read multiple, 1110 memory read line and 1111 memory write and invalidate. For a single address cycle with one of these codes and a hit, devsel_n goes low after the clock edge that follows the edge sampling the address, and never after the sampling edge itself.
- R3: The codes 0100, 0101, 1000 and 1001 are reserved, and 0000, 0001, 1010 and 1011 are not served. The block never claims a transaction with any of these codes, and devsel_n and ctl_oe stay inactive.
- R4: An address is a hit when it lies between win_base and win_limit, both bounds included. An address outside the window is not claimed.
- R5: Code 1101 marks a dual address cycle. The low 32 address bits come with it, and the next clock carries the high 32 bits and the real command. devsel_n goes low one clock later than it does for a single address cycle, and addr_out holds the merged 64-bit address.
- R6: In a claimed data phase trdy_n is low together with devsel_n. xfer_stb is 1 in each clock where irdy_n is also low. After every such transfer addr_out advances by 4 with its two lowest bits kept, and it holds during wait states.
- R7: For a served memory code whose address bits [1:0] are not 00, stop_n is low from the first data phase on. After the first transfer, trdy_n goes high while stop_n and devsel_n stay low, until frame_n and irdy_n are both high.
- R8: After the final transfer (the one where frame_n is high), or after the release that follows a disconnect, the block spends one clock with devsel_n, trdy_n and stop_n high and ctl_oe at 1. In the next clock ctl_oe is 0.
- R9: While a transaction is claimed, cmd_out shows the real command. For a dual address cycle this is the command from the second address clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_n | input | 1 | FRAME#, low while the master owns the transaction |
| irdy_n | input | 1 | IRDY#, low when the master is ready for data |
| cbe_n | input | 4 | Command in address clocks, byte enables in data clocks |
| ad | input | 32 | Address/data bus |
| win_base | input | 64 | Lowest address claimed |
| win_limit | input | 64 | Highest address claimed |
| devsel_n | output | 1 | DEVSEL# value |
| trdy_n | output | 1 | TRDY# value |
| stop_n | output | 1 | STOP# value |
| ctl_oe | output | 1 | Output enable for devsel_n, trdy_n and stop_n |
| claimed | output | 1 | A transaction is claimed |
| cmd_out | output | 4 | Decoded command |
| addr_out | output | 64 | Address of the current data phase |
| xfer_stb | output | 1 | A data transfer completes at the next edge |

## Verification
The assertions assume a master that behaves correctly. A new FRAME# low starts only after the previous transaction has finished. IRDY# stays inactive during address clocks. After it sees STOP#, the master releases FRAME# before it releases IRDY#. The window inputs are also assumed to hold steady for the length of a transaction. The bench drives transactions only through a single task that follows this ordering, and it changes the window only while the bus is idle.

// File: rtl/pci_tgt_pkg.sv
package pci_tgt_pkg;

  localparam logic [3:0] CMD_IO_RD  = 4'b0010;
  localparam logic [3:0] CMD_IO_WR  = 4'b0011;
  localparam logic [3:0] CMD_MEM_RD = 4'b0110;
  localparam logic [3:0] CMD_MEM_WR = 4'b0111;
  localparam logic [3:0] CMD_MRM    = 4'b1100;
  localparam logic [3:0] CMD_DAC    = 4'b1101;
  localparam logic [3:0] CMD_MRL    = 4'b1110;
  localparam logic [3:0] CMD_MWI    = 4'b1111;

  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_DAC  = 3'd1,
    S_DEC  = 3'd2,
    S_DATA = 3'd3,
    S_DISC = 3'd4,
    S_TURN = 3'd5
  } tgt_state_e;

endpackage

// File: rtl/pci_tgt_cmd_dec.sv
module pci_tgt_cmd_dec
  import pci_tgt_pkg::*;
(
  input  logic [3:0] cmd,
  output logic       served,
  output logic       is_mem
);

  always_comb begin
    served = 1'b0;
    is_mem = 1'b0;
    unique case (cmd)
      CMD_IO_RD, CMD_IO_WR: begin
        served = 1'b1;
      end
      CMD_MEM_RD, CMD_MEM_WR, CMD_MRM, CMD_MRL, CMD_MWI: begin
        served = 1'b1;
        is_mem = 1'b1;
      end
      default: begin
        served = 1'b0;
        is_mem = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/pci_tgt_addr_unit.sv
module pci_tgt_addr_unit #(
  parameter int AD_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [AD_W-1:0]     ad,
  input  logic [3:0]          cbe_n,
  input  logic                load_lo,
  input  logic                load_hi,
  input  logic                step,
  input  logic [2*AD_W-1:0]   win_base,
  input  logic [2*AD_W-1:0]   win_limit,
  output logic [2*AD_W-1:0]   addr_q,
  output logic [3:0]          cmd_q,
  output logic                in_win,
  output logic                mode_nz
);

  localparam int ADDR_W   = 2 * AD_W;
  localparam int STEP_LSB = $clog2(AD_W / 8);
  localparam int HI_W     = ADDR_W - STEP_LSB;

  logic [ADDR_W-1:0] addr_d;
  logic [3:0]        cmd_d;
  logic              en;

  assign en = load_lo | load_hi | step;

  always_comb begin
    addr_d = addr_q;
    cmd_d  = cmd_q;
    if (load_lo) begin
      addr_d = {{AD_W{1'b0}}, ad};
      cmd_d  = cbe_n;
    end else if (load_hi) begin
      addr_d[ADDR_W-1:AD_W] = ad;
      cmd_d                 = cbe_n;
    end else if (step) begin
      addr_d[ADDR_W-1:STEP_LSB] = addr_q[ADDR_W-1:STEP_LSB] + HI_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      cmd_q  <= '0;
    end else if (en) begin
      addr_q <= addr_d;
      cmd_q  <= cmd_d;
    end
  end

  assign in_win  = (addr_q >= win_base) && (addr_q <= win_limit);
  assign mode_nz = |addr_q[1:0];

endmodule

// File: rtl/pci_tgt_ctrl.sv
module pci_tgt_ctrl
  import pci_tgt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic frame_n,
  input  logic irdy_n,
  input  logic dac_first,
  input  logic hit,
  input  logic nonlin,
  output logic load_lo,
  output logic load_hi,
  output logic devsel_n,
  output logic trdy_n,
  output logic stop_n,
  output logic ctl_oe,
  output logic claimed,
  output logic xfer_stb
);

  tgt_state_e st_q, st_d;
  logic       frame_q;
  logic       addr_phase;

  assign addr_phase = !frame_n && frame_q;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      S_IDLE: if (addr_phase) st_d = dac_first ? S_DAC : S_DEC;
      S_DAC:  st_d = S_DEC;
      S_DEC:  st_d = hit ? S_DATA : S_IDLE;
      S_DATA: begin
        if (!irdy_n) begin
          if (frame_n)     st_d = S_TURN;
          else if (nonlin) st_d = S_DISC;
        end
      end
      S_DISC: if (frame_n && irdy_n) st_d = S_TURN;
      S_TURN: st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      frame_q <= 1'b1;
    end else begin
      st_q    <= st_d;
      frame_q <= frame_n;
    end
  end

  assign load_lo  = (st_q == S_IDLE) && addr_phase;
  assign load_hi  = (st_q == S_DAC);
  assign claimed  = (st_q == S_DATA) || (st_q == S_DISC);
  assign devsel_n = !claimed;
  assign trdy_n   = !(st_q == S_DATA);
  assign stop_n   = !(((st_q == S_DATA) && nonlin) || (st_q == S_DISC));
  assign ctl_oe   = claimed || (st_q == S_TURN);
  assign xfer_stb = (st_q == S_DATA) && !irdy_n;

  AST_NO_FAST_DEVSEL: assert property (@(posedge clk) disable iff (!rst_n)
    load_lo |=> devsel_n); // R2
  AST_MISS_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == S_DEC) && !hit) |=> (devsel_n && !ctl_oe)); // R3
  AST_TRDY_WITH_DEVSEL: assert property (@(posedge clk) disable iff (!rst_n)
    !trdy_n |-> !devsel_n); // R6
  AST_STOP_WITH_DEVSEL: assert property (@(posedge clk) disable iff (!rst_n)
    !stop_n |-> !devsel_n); // R7
  AST_DISC_AFTER_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    (!stop_n && xfer_stb && !frame_n) |=> (trdy_n && !stop_n)); // R7
  AST_TURN_DRIVES_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(devsel_n) |-> (ctl_oe && trdy_n && stop_n)); // R8

endmodule

// File: rtl/pci_tgt_decode.sv
module pci_tgt_decode
  import pci_tgt_pkg::*;
#(
  parameter int AD_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                frame_n,
  input  logic                irdy_n,
  input  logic [3:0]          cbe_n,
  input  logic [AD_W-1:0]     ad,
  input  logic [2*AD_W-1:0]   win_base,
  input  logic [2*AD_W-1:0]   win_limit,
  output logic                devsel_n,
  output logic                trdy_n,
  output logic                stop_n,
  output logic                ctl_oe,
  output logic                claimed,
  output logic [3:0]          cmd_out,
  output logic [2*AD_W-1:0]   addr_out,
  output logic                xfer_stb
);

  localparam int ADDR_W = 2 * AD_W;

  logic       rst_meta, rst_s;
  logic       load_lo, load_hi;
  logic       served, is_mem, in_win, mode_nz;
  logic [ADDR_W-1:0] addr_q;
  logic [3:0] cmd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_s    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_s    <= rst_meta;
    end
  end

  pci_tgt_addr_unit #(.AD_W(AD_W)) u_addr (
    .clk       (clk),
    .rst_n     (rst_s),
    .ad        (ad),
    .cbe_n     (cbe_n),
    .load_lo   (load_lo),
    .load_hi   (load_hi),
    .step      (xfer_stb),
    .win_base  (win_base),
    .win_limit (win_limit),
    .addr_q    (addr_q),
    .cmd_q     (cmd_q),
    .in_win    (in_win),
    .mode_nz   (mode_nz)
  );

  pci_tgt_cmd_dec u_cmd (
    .cmd    (cmd_q),
    .served (served),
    .is_mem (is_mem)
  );

  pci_tgt_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_s),
    .frame_n   (frame_n),
    .irdy_n    (irdy_n),
    .dac_first (cbe_n == CMD_DAC),
    .hit       (served && in_win),
    .nonlin    (is_mem && mode_nz),
    .load_lo   (load_lo),
    .load_hi   (load_hi),
    .devsel_n  (devsel_n),
    .trdy_n    (trdy_n),
    .stop_n    (stop_n),
    .ctl_oe    (ctl_oe),
    .claimed   (claimed),
    .xfer_stb  (xfer_stb)
  );

  assign cmd_out  = cmd_q;
  assign addr_out = addr_q;

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_s)
    (claimed && !xfer_stb) |=> $stable(addr_out)); // R6
  AST_CMD_STABLE: assert property (@(posedge clk) disable iff (!rst_s)
    (claimed && $past(claimed)) |-> $stable(cmd_out)); // R9

endmodule

// File: tb/pci_tgt_decode_bench.sv
module pci_tgt_decode_bench;

  localparam int CLK_P = 10;

  typedef struct {
    logic [63:0] a;
    logic [3:0]  c;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_n = 1'b1;
  logic        irdy_n = 1'b1;
  logic [3:0]  cbe_n = 4'hF;
  logic [31:0] ad = '0;
  logic [63:0] win_base = '0;
  logic [63:0] win_limit = '0;
  logic        devsel_n, trdy_n, stop_n, ctl_oe, claimed, xfer_stb;
  logic [3:0]  cmd_out;
  logic [63:0] addr_out;

  int   n_tests = 0;
  int   n_fail  = 0;
  bit   done    = 1'b0;
  exp_t exp_q[$];

  always #(CLK_P/2) clk = ~clk;

  pci_tgt_decode u_pci_tgt_decode (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n),
    .cbe_n(cbe_n), .ad(ad), .win_base(win_base), .win_limit(win_limit),
    .devsel_n(devsel_n), .trdy_n(trdy_n), .stop_n(stop_n), .ctl_oe(ctl_oe),
    .claimed(claimed), .cmd_out(cmd_out), .addr_out(addr_out), .xfer_stb(xfer_stb)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #2;
  endtask

  function automatic bit mem_code(input logic [3:0] c);
    return (c == 4'b0110) || (c == 4'b0111) || (c == 4'b1100) ||
           (c == 4'b1110) || (c == 4'b1111);
  endfunction

  // Monitor: compares every completed transfer against the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && xfer_stb) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R6", "unexpected transfer at", addr_out, 64'h0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          chk(addr_out == e.a, "R6", "transfer address", addr_out, e.a);
          chk(cmd_out == e.c, "R9", "transfer command", {60'h0, cmd_out}, {60'h0, e.c});
          chk(claimed == 1'b1, "R6", "claimed during transfer", {63'h0, claimed}, 64'h1);
        end
      end
    end
  end

  // Driver: one master transaction, pushes the expected transfers
  task automatic txn(input bit dac, input logic [3:0] cmd, input logic [63:0] a,
                     input int n, input bit exp_claim, input bit waitst, input string req);
    bit nl;
    nl = mem_code(cmd) && (a[1:0] != 2'b00);
    if (exp_claim) begin
      for (int k = 0; k < (nl ? 1 : n); k++) begin
        exp_t e;
        e.a = {a[63:2] + 62'(k), a[1:0]};
        e.c = cmd;
        exp_q.push_back(e);
      end
    end
    frame_n = 1'b0; ad = a[31:0]; cbe_n = dac ? 4'b1101 : cmd;
    cyc();
    if (dac) begin
      chk(devsel_n == 1'b1, "R5", "devsel during high address clock", {63'h0, devsel_n}, 64'h1);
      ad = a[63:32]; cbe_n = cmd;
      cyc();
    end
    chk(devsel_n == 1'b1, "R2", "devsel one clock after address", {63'h0, devsel_n}, 64'h1);
    cbe_n = 4'h0; ad = '0; irdy_n = 1'b0; frame_n = (n == 1);
    cyc();
    chk(devsel_n == !exp_claim, req, "devsel at medium timing", {63'h0, devsel_n}, {63'h0, !exp_claim});
    if (!exp_claim) begin
      chk(ctl_oe == 1'b0, req, "ctl_oe on ignored cycle", {63'h0, ctl_oe}, 64'h0);
      frame_n = 1'b1; irdy_n = 1'b1;
      cyc();
      chk(devsel_n && !ctl_oe, req, "still released after abort", {63'h0, ctl_oe}, 64'h0);
      cyc();
      return;
    end
    chk(cmd_out == cmd, "R9", "command while claimed", {60'h0, cmd_out}, {60'h0, cmd});
    if (dac) chk(addr_out == a, "R5", "merged address", addr_out, a);
    for (int k = 0; k < n; k++) begin
      if (waitst && k == 1) begin
        irdy_n = 1'b1;
        cyc();
        chk(trdy_n == 1'b0, "R6", "trdy held in wait state", {63'h0, trdy_n}, 64'h0);
        chk(addr_out == {a[63:2] + 62'd1, a[1:0]}, "R6", "address held in wait",
            addr_out, {a[63:2] + 62'd1, a[1:0]});
        irdy_n = 1'b0;
      end
      chk(trdy_n == 1'b0, "R6", "trdy in data phase", {63'h0, trdy_n}, 64'h0);
      chk(stop_n == !nl, "R7", "stop in data phase", {63'h0, stop_n}, {63'h0, !nl});
      cyc();
      if (nl && n > 1) begin
        chk(trdy_n == 1'b1, "R7", "trdy after first transfer", {63'h0, trdy_n}, 64'h1);
        chk(!stop_n && !devsel_n, "R7", "stop/devsel held", {62'h0, stop_n, devsel_n}, 64'h0);
        frame_n = 1'b1;
        cyc();
        chk(!stop_n && !devsel_n && trdy_n, "R7", "disconnect until irdy released",
            {61'h0, stop_n, devsel_n, trdy_n}, 64'h1);
        irdy_n = 1'b1;
        cyc();
        break;
      end
      if (k < n - 1) frame_n = (k + 1 == n - 1);
    end
    chk(devsel_n && trdy_n && stop_n && ctl_oe, "R8", "turnaround clock",
        {60'h0, devsel_n, trdy_n, stop_n, ctl_oe}, 64'hF);
    irdy_n = 1'b1; frame_n = 1'b1; cbe_n = 4'hF;
    cyc();
    chk(ctl_oe == 1'b0, "R8", "release after turnaround", {63'h0, ctl_oe}, 64'h0);
    cyc();
  endtask

  initial begin
    repeat (3) cyc();
    chk(devsel_n && trdy_n && stop_n, "R1", "controls in reset",
        {61'h0, devsel_n, trdy_n, stop_n}, 64'h7);
    chk(!ctl_oe && !claimed && !xfer_stb, "R1", "flags in reset",
        {61'h0, ctl_oe, claimed, xfer_stb}, 64'h0);
    rst_n = 1'b1;
    repeat (4) cyc();
    chk(devsel_n && !ctl_oe && !claimed, "R1", "idle after reset",
        {61'h0, devsel_n, ctl_oe, claimed}, 64'h4);

    win_base  = 64'h0000_0000_1000_0000;
    win_limit = 64'h0000_0000_1000_00FF;
    txn(1'b0, 4'b0110, 64'h0000_0000_1000_0000, 3, 1'b1, 1'b1, "R2");
    txn(1'b0, 4'b0100, 64'h0000_0000_1000_0010, 1, 1'b0, 1'b0, "R3");
    txn(1'b0, 4'b1000, 64'h0000_0000_1000_0010, 1, 1'b0, 1'b0, "R3");
    txn(1'b0, 4'b1010, 64'h0000_0000_1000_0010, 1, 1'b0, 1'b0, "R3");
    txn(1'b0, 4'b0111, 64'h0000_0000_1000_0100, 2, 1'b0, 1'b0, "R4");
    txn(1'b0, 4'b0111, 64'h0000_0000_0FFF_FFFC, 2, 1'b0, 1'b0, "R4");
    txn(1'b0, 4'b0111, 64'h0000_0000_1000_00FC, 1, 1'b1, 1'b0, "R4");
    txn(1'b0, 4'b0011, 64'h0000_0000_1000_0002, 1, 1'b1, 1'b0, "R2");
    txn(1'b0, 4'b1110, 64'h0000_0000_1000_0011, 3, 1'b1, 1'b0, "R7");
    txn(1'b0, 4'b1111, 64'h0000_0000_1000_0042, 1, 1'b1, 1'b0, "R7");

    win_base  = 64'h0000_0001_0000_0000;
    win_limit = 64'h0000_0001_0000_0FFF;
    txn(1'b1, 4'b0111, 64'h0000_0001_0000_0040, 4, 1'b1, 1'b0, "R5");
    txn(1'b1, 4'b1100, 64'h0000_0002_0000_0040, 2, 1'b0, 1'b0, "R5");
    txn(1'b0, 4'b0110, 64'h0000_0000_0000_0040, 1, 1'b0, 1'b0, "R4");

    chk(exp_q.size() == 0, "R6", "scoreboard drained", 64'(exp_q.size()), 64'h0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "R1", "watchdog expired", 64'h0, 64'h1);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule